// File: doc/BRIEF.md
# Indirect-access lookup entry table

This block holds a table of 68-bit lookup entries that a host reaches only through a small register window. The host sees an identification register, a global control register, a table-control register and three 32-bit data words. Software fetches an entry by writing its index to table-control with the write flag clear. The entry is then copied into the data words, where the host can read it. To store an entry, software fills the data words and then writes the index with the write flag set. The data words are copied into that entry.

A global clear command marks every entry as free. It sweeps the table one entry per clock and clears only the 2-bit type field of each entry. While the sweep runs, the clear bit reads back as 1. The host bus stays usable during the sweep, so table commits can land while it is still in progress. The table depth is a parameter. An index beyond the table is harmless: a store to it is dropped and a fetch from it returns zeros.

Top module: `et_window`

## Requirements
- R1: The register at offset 0x00 reads {16'b0, major[15:8], minor[7:0]}, which is 0x00000104 with the default parameters. Any offset outside the register map reads 0, and writes to it have no effect.
- R2: In the control register at offset 0x08, bit 31 is a read/write enable bit. Bits 29:0 read 0. The enable bit keeps its value through a clear sweep.
- R3: A write to offset 0x20 with bit 31 clear is a fetch. It copies the entry selected by bits 9:0 into the data words on the clock edge that accepts the write, so the next bus cycle reads the new contents. Offset 0x20 reads back the last index in bits 9:0, and bit 31 always reads 0.
- R4: A write to offset 0x20 with bit 31 set is a store. It copies the 68-bit data-word contents into the entry at the index in bits 9:0. The data words keep their value.
- R5: Entry bit n lives in the data word at offset 0x34 + 4*(2 - n/32), at bit position n mod 32. The word at 0x34 holds only entry bits 67:64, in its bits 3:0. Its bits 31:4 read 0 and are ignored on write.
- R6: An index equal to or greater than DEPTH is handled as follows. A store to it changes no entry. A fetch from it loads all zeros into the data words.
- R7: Writing 1 to control bit 30 starts a sweep. The sweep sets entry bits 61:60 to 0 and leaves all other bits of the entry unchanged. It clears one entry per cycle, in index order from 0 upward. Entry k is cleared on the (k+1)-th clock edge after the edge that accepted the write.
- R8: After the edge that accepts the clear command, control bit 30 reads 1 for exactly DEPTH cycles and then 0. Writing bit 30 again while a sweep runs neither restarts it nor extends it.
- R9: A store to the entry the sweep clears in that same cycle keeps all of the stored data. A store to an entry the sweep has already passed is kept. A store to an entry the sweep has not yet reached has its bits 61:60 cleared when the sweep gets there.
- R10: After reset, every entry, the data words, the enable bit and the table-control index are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The clear sweep and a host store through table-control can both write the table in the same cycle. The bench starts a sweep and then counts clock edges. It places a store on the exact edge at which the sweep clears that same index. It places a second store on an index the sweep has already passed, and a third on an index the sweep has not reached yet. A repeated clear command is also placed in the middle of the sweep. Afterwards the bench fetches each of these entries and compares the type field and the neighbouring bits with the R9 rules. It also measures the remaining busy time to show that the repeated clear command did not extend the sweep.

// File: rtl/et_pkg.sv
package et_pkg;
    localparam int ENTRY_W = 68;
    localparam int WORD_W  = 32;
    localparam int PAD_W   = 3 * WORD_W;
    localparam int TYPE_LO = 60;

    localparam logic [7:0] A_ID    = 8'h00;
    localparam logic [7:0] A_CTRL  = 8'h08;
    localparam logic [7:0] A_TCTL  = 8'h20;
    localparam logic [7:0] A_DATA0 = 8'h34;
    localparam logic [7:0] A_DATA1 = 8'h38;
    localparam logic [7:0] A_DATA2 = 8'h3C;

    localparam int CTL_EN_BIT  = 31;
    localparam int CTL_CLR_BIT = 30;
    localparam int TC_WR_BIT   = 31;

    typedef logic [ENTRY_W-1:0] entry_t;

    // word k carries entry bits [(2-k)*32 +: 32]
    function automatic logic [WORD_W-1:0] word_of(entry_t e, int k);
        logic [PAD_W-1:0] pad;
        pad = {{(PAD_W-ENTRY_W){1'b0}}, e};
        return pad[(2-k)*WORD_W +: WORD_W];
    endfunction

    function automatic entry_t put_word(entry_t e, int k, logic [WORD_W-1:0] w);
        logic [PAD_W-1:0] pad;
        pad = {{(PAD_W-ENTRY_W){1'b0}}, e};
        pad[(2-k)*WORD_W +: WORD_W] = w;
        return pad[ENTRY_W-1:0];
    endfunction
endpackage

// File: rtl/et_store.sv
module et_store
    import et_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_data,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_data
);
    entry_t mem [DEPTH];

    // host store is applied after the sweep clear, so it wins on a shared index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (clr_en) mem[clr_idx][TYPE_LO +: 2] <= 2'b00;
            if (wr_en)  mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/et_sweep.sv
module et_sweep #(
    parameter int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } sweep_t;

    sweep_t sw_d, sw_q;

    always_comb begin
        sw_d = sw_q;
        if (!sw_q.busy) begin
            if (start) begin
                sw_d.busy = 1'b1;
                sw_d.idx  = '0;
            end
        end else if (sw_q.idx == LAST) begin
            sw_d.busy = 1'b0;
        end else begin
            sw_d.idx = sw_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_d;
    end

    assign busy    = sw_q.busy;
    assign clr_en  = sw_q.busy;
    assign clr_idx = sw_q.idx;
endmodule

// File: rtl/et_window.sv
module et_window
    import et_pkg::*;
#(
    parameter int         DEPTH     = 64,
    parameter int         IDX_FW    = 10,
    parameter logic [7:0] VER_MAJOR = 8'd1,
    parameter logic [7:0] VER_MINOR = 8'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr_en,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_FW:0] DEPTH_V = (IDX_FW+1)'(DEPTH);

    typedef struct packed {
        logic              en;
        logic [IDX_FW-1:0] tc_idx;
        entry_t            dw;
    } win_t;

    win_t st_d, st_q;

    logic [IDX_FW-1:0] req_idx;
    logic              idx_ok;
    logic              tc_hit;
    logic              store_en;
    logic              sweep_start;
    logic              sweep_busy;
    logic              clr_en;
    logic [IDX_W-1:0]  clr_idx;
    entry_t            rd_entry;

    assign req_idx     = bus_wdata[IDX_FW-1:0];
    assign idx_ok      = {1'b0, req_idx} < DEPTH_V;
    assign tc_hit      = bus_wr_en && (bus_addr == A_TCTL);
    assign store_en    = tc_hit && bus_wdata[TC_WR_BIT] && idx_ok;
    assign sweep_start = bus_wr_en && (bus_addr == A_CTRL) && bus_wdata[CTL_CLR_BIT];

    et_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_idx  (req_idx[IDX_W-1:0]),
        .wr_data (st_q.dw),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .rd_idx  (req_idx[IDX_W-1:0]),
        .rd_data (rd_entry)
    );

    et_sweep #(.DEPTH(DEPTH)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sweep_start),
        .busy    (sweep_busy),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    always_comb begin
        st_d = st_q;
        if (bus_wr_en) begin
            unique case (bus_addr)
                A_CTRL:  st_d.en = bus_wdata[CTL_EN_BIT];
                A_DATA0: st_d.dw = put_word(st_q.dw, 0, bus_wdata);
                A_DATA1: st_d.dw = put_word(st_q.dw, 1, bus_wdata);
                A_DATA2: st_d.dw = put_word(st_q.dw, 2, bus_wdata);
                A_TCTL: begin
                    st_d.tc_idx = req_idx;
                    if (!bus_wdata[TC_WR_BIT]) st_d.dw = idx_ok ? rd_entry : '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (bus_addr)
            A_ID:    bus_rdata = {16'b0, VER_MAJOR, VER_MINOR};
            A_CTRL:  bus_rdata = {st_q.en, sweep_busy, 30'b0};
            A_TCTL:  bus_rdata = {{(32-IDX_FW){1'b0}}, st_q.tc_idx};
            A_DATA0: bus_rdata = word_of(st_q.dw, 0);
            A_DATA1: bus_rdata = word_of(st_q.dw, 1);
            A_DATA2: bus_rdata = word_of(st_q.dw, 2);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/et_window_chk.sv
module et_window_chk #(
    parameter int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 2) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic [31:4]      rdata_hi,
    input logic             clr_req,
    input logic             sweep_busy,
    input logic             clr_en,
    input logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEP_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run_cnt <= '0;
        else if (sweep_busy) run_cnt <= run_cnt + 1'b1;
        else                 run_cnt <= '0;
    end

    AST_SWEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_en) |-> clr_idx == '0); // R7
    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_idx != LAST) |=> (clr_en && clr_idx == $past(clr_idx) + 1'b1)); // R7
    AST_SWEEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sweep_busy) |-> run_cnt == DEP_C); // R8
    AST_CLR_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> sweep_busy); // R8
    AST_W0_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 8'h34 |-> rdata_hi == '0); // R5
    AST_TC_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 8'h20 |-> !rdata_hi[31]); // R3
    AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 8'h00 |-> rdata_hi[31:16] == '0); // R1
endmodule

bind et_window et_window_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .rdata_hi   (bus_rdata[31:4]),
    .clr_req    (bus_wr_en && bus_addr == 8'h08 && bus_wdata[30]),
    .sweep_busy (sweep_busy),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx)
);

// File: tb/sim_et_window.sv
module sim_et_window;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2ns clk = ~clk;

    et_window u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'h0000_0104, 8'd1},  // R1 identification
        '{1'b1, 8'h08, 32'h0000_0000, 8'd10}, // R10 reset control
        '{1'b1, 8'h20, 32'h0000_0000, 8'd10}, // R10 reset index
        '{1'b1, 8'h3C, 32'h0000_0000, 8'd10}, // R10 reset data word
        '{1'b0, 8'h08, 32'h8000_0000, 8'd2},
        '{1'b1, 8'h08, 32'h8000_0000, 8'd2},  // R2 enable readback
        '{1'b0, 8'h3C, 32'h1122_3344, 8'd5},
        '{1'b0, 8'h38, 32'h5566_7788, 8'd5},
        '{1'b0, 8'h34, 32'hFFFF_FFF9, 8'd5},
        '{1'b1, 8'h34, 32'h0000_0009, 8'd5},  // R5 top word only 4 bits
        '{1'b0, 8'h20, 32'h8000_0005, 8'd4},
        '{1'b1, 8'h3C, 32'h1122_3344, 8'd4},  // R4 data words kept
        '{1'b0, 8'h3C, 32'h0000_0000, 8'd3},
        '{1'b0, 8'h38, 32'h0000_0000, 8'd3},
        '{1'b0, 8'h34, 32'h0000_0000, 8'd3},
        '{1'b0, 8'h20, 32'h0000_0005, 8'd3},
        '{1'b1, 8'h20, 32'h0000_0005, 8'd3},  // R3 index readback
        '{1'b1, 8'h3C, 32'h1122_3344, 8'd3},  // R3 fetch low word
        '{1'b1, 8'h38, 32'h5566_7788, 8'd3},  // R3 fetch middle word
        '{1'b1, 8'h34, 32'h0000_0009, 8'd5},  // R5 fetch top bits
        '{1'b0, 8'h20, 32'h0000_0007, 8'd10},
        '{1'b1, 8'h38, 32'h0000_0000, 8'd10}, // R10 untouched entry zero
        '{1'b1, 8'h50, 32'h0000_0000, 8'd1}   // R1 unmapped offset
    };

    // all tasks start and end on a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1ns;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic fetch_word(input int idx, input logic [7:0] a, output logic [31:0] d);
        wr(8'h20, 32'(idx));
        rd(a, d);
    endtask

    task automatic poll_busy(output int cnt);
        cnt = 0;
        bus_addr = 8'h08;
        for (int i = 0; i < 4 * DEPTH; i++) begin
            #1ns;
            if (!bus_rdata[30]) break;
            cnt++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        #800us;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                rd(VECS[i].addr, v);
                chk(int'(VECS[i].req), v, VECS[i].data);
            end else begin
                wr(VECS[i].addr, VECS[i].data);
            end
        end

        // R6: store to index DEPTH must not alias onto entry 0
        wr(8'h3C, 32'hDEAD_BEEF);
        wr(8'h38, 32'h3000_0001);
        wr(8'h34, 32'h0000_0003);
        wr(8'h20, 32'h8000_0000 | 32'(DEPTH));
        fetch_word(0, 8'h3C, v); chk(6, v, 32'h0);        // R6 entry 0 untouched
        rd(8'h38, v);            chk(6, v, 32'h0);        // R6
        wr(8'h3C, 32'h0000_1234);
        fetch_word(DEPTH, 8'h3C, v); chk(6, v, 32'h0);    // R6 fetch out of range
        wr(8'h3C, 32'h0000_5678);
        fetch_word(1023, 8'h3C, v); chk(6, v, 32'h0);     // R6 largest index

        // R7/R8: full sweep
        wr(8'h3C, 32'h0000_ABCD);
        wr(8'h38, 32'h3FFF_0000);
        wr(8'h34, 32'h0000_000A);
        wr(8'h20, 32'h8000_0000 | 32'(DEPTH - 1));
        wr(8'h08, 32'hC000_0000);
        poll_busy(cnt);
        chk(8, 32'(cnt), 32'(DEPTH));                      // R8 busy length
        rd(8'h08, v); chk(2, v, 32'h8000_0000);            // R2 enable kept, clear bit low
        fetch_word(DEPTH - 1, 8'h38, v); chk(7, v, 32'h0FFF_0000); // R7 type cleared
        rd(8'h3C, v); chk(7, v, 32'h0000_ABCD);            // R7 low bits intact
        rd(8'h34, v); chk(7, v, 32'h0000_000A);            // R7 top bits intact
        fetch_word(5, 8'h38, v); chk(7, v, 32'h4566_7788); // R7 entry 5 type cleared

        // R9: stores racing the sweep
        wr(8'h3C, 32'hAAAA_5555);
        wr(8'h38, 32'h3000_0ABC);
        wr(8'h34, 32'h0000_0005);
        wr(8'h20, 32'h8000_000A);
        wr(8'h08, 32'hC000_0000);                          // accepted on edge E0
        repeat (20) @(negedge clk);
        wr(8'h20, 32'h8000_0014);                          // E0+21: same edge clears 20
        wr(8'h20, 32'h8000_0003);                          // E0+22: entry 3 already swept
        wr(8'h08, 32'hC000_0000);                          // E0+23: repeat clear, R8 ignored
        wr(8'h20, 32'h8000_0028);                          // E0+24: entry 40 not reached
        poll_busy(cnt);
        chk(8, 32'(cnt), 32'(DEPTH - 24));                 // R8 no restart
        fetch_word(20, 8'h38, v); chk(9, v, 32'h3000_0ABC); // R9 same-cycle store wins
        rd(8'h3C, v);             chk(9, v, 32'hAAAA_5555); // R9
        fetch_word(3, 8'h38, v);  chk(9, v, 32'h3000_0ABC); // R9 passed entry kept
        fetch_word(40, 8'h38, v); chk(9, v, 32'h0000_0ABC); // R9 later entry cleared
        rd(8'h34, v);             chk(9, v, 32'h0000_0005); // R9 other bits intact
        fetch_word(10, 8'h38, v); chk(7, v, 32'h0000_0ABC); // R7 prior entry cleared

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule